// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. Software-facing logic elsewhere drops a byte into a holding register with a one-cycle load strobe. The block moves that byte into a shift register and sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. A three-bit format code picks one of eight frame layouts. A two-bit divide code sets each bit to 1, 16 or 64 transmit ticks. The same divide code, when set to its fourth value, acts as a master reset.

The transmit tick is a one-cycle enable in the system clock domain. The line changes only at clock edges where that tick is high. A two-bit transmit-control code can force a continuous break, which holds the line low. A second character written while a frame is in progress waits in the holding register and follows the current frame with no idle gap. Address decoding, modem handshake gating and interrupt generation belong to neighbouring blocks.

Top module: `asyncTx`

## Requirements
- R1: After reset is released, `txLine` is high (idle) and `holdEmpty` is 1.
- R2: A frame begins at the first tick edge after the holding register fills. It is a low start bit, then the data bits least significant first, then the parity bit when one is selected, then high stop bits. The line is high again once the frame ends.
- R3: `wordSel` selects the frame format: 000 = 7 data, even parity, 2 stops; 001 = 7 data, odd parity, 2 stops; 010 = 7 data, even parity, 1 stop; 011 = 7 data, odd parity, 1 stop; 100 = 8 data, no parity, 2 stops; 101 = 8 data, no parity, 1 stop; 110 = 8 data, even parity, 1 stop; 111 = 8 data, odd parity, 1 stop.
- R4: With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number of ones. With no parity, no parity bit is sent.
- R5: In the 7-data-bit formats, bit 7 of `loadData` has no effect on the line.
- R6: Every bit of a frame lasts 1, 16 or 64 ticks for `divSel` = 00, 01 or 10 respectively.
- R7: `holdEmpty` goes low in the cycle after a load strobe. It returns high at the tick edge where that character starts shifting.
- R8: A character loaded while a frame is in progress starts at the tick edge that ends the final stop bit of the current frame, with no idle slot between the two frames.
- R9: While `txCtrl` = 11 the line is held low (break). The codes 00, 01 and 10 have no effect on the frame.
- R10: While `divSel` = 11 any frame in progress is aborted, the line goes high and `holdEmpty` is set. A load strobe in that state is ignored, so no frame follows the reset.
- R11: Apart from break and master reset, `txLine` changes only at clock edges where `txTick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txTick | input | 1 | Transmit clock enable, one pulse per tick |
| divSel | input | 2 | Ticks per bit: 00 = 1, 01 = 16, 10 = 64; 11 = master reset |
| wordSel | input | 3 | Frame format code (R3) |
| txCtrl | input | 2 | Transmit control; 11 = break |
| loadStrobe | input | 1 | Writes `loadData` into the holding register |
| loadData | input | 8 | Character to send |
| txLine | output | 1 | Serial output, idles high |
| holdEmpty | output | 1 | Holding register is free for a new character |

## Verification
A wrong bit counter or divider count shows as a frame that is a tick too long or too short. That error appears at the stop bit, or as a following frame that starts one slot early or late, within a single frame time. A stale holding-full flag shows at `holdEmpty` in the cycle after a load or a frame start, or as a phantom frame after a master reset. The bench therefore records the line once per tick and compares the whole tick stream, idle slots included, against frames it builds itself. This is done for every format, every divisor and irregular tick spacing.

// File: rtl/asyncTxPkg.sv
package asyncTxPkg;

  localparam int FRAME_MAX = 12;
  localparam int LEN_W = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic loadHold;
    logic startFrame;
    logic shiftBit;
    logic goIdle;
    logic abort;
  } txStrobes_t;

  // Number of bit slots in a frame: start + data + optional parity + stops.
  function automatic logic [LEN_W-1:0] frameLength(input logic [2:0] ws);
    logic [LEN_W-1:0] n;
    n = LEN_W'(1) + (ws[2] ? LEN_W'(8) : LEN_W'(7));
    if (!ws[2] || ws[1]) n = n + LEN_W'(1);
    n = n + ((ws == 3'b100 || (!ws[2] && !ws[1])) ? LEN_W'(2) : LEN_W'(1));
    return n;
  endfunction

  // Frame image, bit 0 is sent first; unused upper slots stay high.
  function automatic logic [FRAME_MAX-1:0] buildFrame(input logic [7:0] data,
                                                       input logic [2:0] ws);
    logic [FRAME_MAX-1:0] f;
    logic [7:0] masked;
    logic parityBit;
    masked = ws[2] ? data : {1'b0, data[6:0]};
    parityBit = (^masked) ^ ws[0];
    f = '1;
    f[0] = 1'b0;
    f[7:1] = masked[6:0];
    if (ws[2]) begin
      f[8] = masked[7];
      if (ws[1]) f[9] = parityBit;
    end else begin
      f[8] = parityBit;
    end
    return f;
  endfunction

endpackage

// File: rtl/asyncTxControl.sv
module asyncTxControl
  import asyncTxPkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txTick,
  input  logic       loadStrobe,
  input  logic [1:0] divSel,
  input  logic [2:0] wordSel,
  output txStrobes_t strobes,
  output logic       holdEmpty
);

  localparam int CNT_W = $clog2(DIV_HIGH);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLimit;
  logic [LEN_W-1:0] bitsLeft;
  logic busy;
  logic holdFull;
  logic masterRst;
  logic bitDone;
  logic lastBit;

  always_comb begin
    masterRst = (divSel == 2'b11);
    unique case (divSel)
      2'b00:   divLimit = '0;
      2'b01:   divLimit = CNT_W'(DIV_MID - 1);
      default: divLimit = CNT_W'(DIV_HIGH - 1);
    endcase
    bitDone = busy && txTick && (divCnt == divLimit);
    lastBit = bitDone && (bitsLeft == '0);
    strobes.abort      = masterRst;
    strobes.loadHold   = loadStrobe && !masterRst;
    strobes.startFrame = !masterRst && txTick && holdFull && (!busy || lastBit);
    strobes.shiftBit   = !masterRst && bitDone && !lastBit;
    strobes.goIdle     = !masterRst && lastBit && !strobes.startFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      holdFull <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= '0;
    end else if (strobes.abort) begin
      busy     <= 1'b0;
      holdFull <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= '0;
    end else begin
      if (strobes.startFrame) begin
        busy     <= 1'b1;
        divCnt   <= '0;
        bitsLeft <= frameLength(wordSel) - LEN_W'(1);
      end else if (strobes.goIdle) begin
        busy   <= 1'b0;
        divCnt <= '0;
      end else if (strobes.shiftBit) begin
        divCnt   <= '0;
        bitsLeft <= bitsLeft - LEN_W'(1);
      end else if (busy && txTick) begin
        divCnt <= divCnt + CNT_W'(1);
      end
      // A load in the same cycle as a start keeps the register full.
      if (strobes.loadHold) holdFull <= 1'b1;
      else if (strobes.startFrame) holdFull <= 1'b0;
    end
  end

  assign holdEmpty = !holdFull;

endmodule

// File: rtl/asyncTxDatapath.sv
module asyncTxDatapath
  import asyncTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  txStrobes_t strobes,
  input  logic [7:0] loadData,
  input  logic [2:0] wordSel,
  input  logic [1:0] txCtrl,
  output logic       txLine
);

  logic [7:0] holdReg;
  logic [FRAME_MAX-1:0] shiftReg;
  logic [FRAME_MAX-1:0] nextFrame;
  logic lineReg;

  assign nextFrame = buildFrame(holdReg, wordSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
      lineReg  <= 1'b1;
    end else begin
      if (strobes.loadHold) holdReg <= loadData;
      if (strobes.abort) begin
        shiftReg <= '1;
        lineReg  <= 1'b1;
      end else if (strobes.startFrame) begin
        lineReg  <= nextFrame[0];
        shiftReg <= {1'b1, nextFrame[FRAME_MAX-1:1]};
      end else if (strobes.shiftBit) begin
        lineReg  <= shiftReg[0];
        shiftReg <= {1'b1, shiftReg[FRAME_MAX-1:1]};
      end else if (strobes.goIdle) begin
        lineReg <= 1'b1;
      end
    end
  end

  assign txLine = (txCtrl == 2'b11) ? 1'b0 : lineReg;

endmodule

// File: rtl/asyncTx.sv
module asyncTx
  import asyncTxPkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txTick,
  input  logic [1:0] divSel,
  input  logic [2:0] wordSel,
  input  logic [1:0] txCtrl,
  input  logic       loadStrobe,
  input  logic [7:0] loadData,
  output logic       txLine,
  output logic       holdEmpty
);

  txStrobes_t strobes;

  asyncTxControl #(.DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .txTick(txTick),
    .loadStrobe(loadStrobe),
    .divSel(divSel),
    .wordSel(wordSel),
    .strobes(strobes),
    .holdEmpty(holdEmpty)
  );

  asyncTxDatapath u_data (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .loadData(loadData),
    .wordSel(wordSel),
    .txCtrl(txCtrl),
    .txLine(txLine)
  );

endmodule

// File: rtl/asyncTxChecker.sv
module asyncTxChecker (
  input logic       clk,
  input logic       rstN,
  input logic       txTick,
  input logic [1:0] divSel,
  input logic [1:0] txCtrl,
  input logic       loadStrobe,
  input logic       txLine,
  input logic       holdEmpty
);

  // R9: a break held over two cycles keeps the line low
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txCtrl == 2'b11 && $past(txCtrl) == 2'b11) |-> !txLine);

  // R10: master reset frees the holding register
  p_reset_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b11) |=> holdEmpty);

  // R10: master reset returns the line to idle unless a break is forced
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b11) |=> (txLine || txCtrl == 2'b11));

  // R7: a load fills the holding register in the next cycle
  p_load_fills_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && divSel != 2'b11) |=> !holdEmpty);

  // R7: the holding register only becomes full through a load
  p_fill_needs_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdEmpty) |-> $past(loadStrobe));

  // R11: without a tick the line holds unless break control moved
  p_tick_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!txTick && divSel != 2'b11) |=>
      (txLine == $past(txLine) || txCtrl != $past(txCtrl)));

endmodule

bind asyncTx asyncTxChecker u_chk (
  .clk(clk),
  .rstN(rstN),
  .txTick(txTick),
  .divSel(divSel),
  .txCtrl(txCtrl),
  .loadStrobe(loadStrobe),
  .txLine(txLine),
  .holdEmpty(holdEmpty)
);

// File: tb/tb_asyncTx.sv
module tb_asyncTx;

  localparam int LOG_MAX = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txTick = 1'b0;
  logic [1:0] divSel = 2'b00;
  logic [2:0] wordSel = 3'b000;
  logic [1:0] txCtrl = 2'b00;
  logic loadStrobe = 1'b0;
  logic [7:0] loadData = 8'h00;
  logic txLine;
  logic holdEmpty;

  int errors = 0;
  int checks = 0;
  bit lineLog[LOG_MAX];
  bit expStream[LOG_MAX];
  int logN = 0;
  int expN = 0;

  asyncTx dut (
    .clk(clk), .rstN(rstN), .txTick(txTick), .divSel(divSel),
    .wordSel(wordSel), .txCtrl(txCtrl), .loadStrobe(loadStrobe),
    .loadData(loadData), .txLine(txLine), .holdEmpty(holdEmpty)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int divOf(input logic [1:0] ds);
    return (ds == 2'b00) ? 1 : (ds == 2'b01) ? 16 : 64;
  endfunction

  function automatic int expLen(input logic [2:0] ws);
    case (ws)
      3'b000, 3'b001, 3'b100, 3'b110, 3'b111: return 11;
      default: return 10;
    endcase
  endfunction

  function automatic bit expBit(input logic [7:0] d, input logic [2:0] ws, input int i);
    int nd;
    int ones;
    bit hasPar;
    nd = ws[2] ? 8 : 7;
    hasPar = (ws != 3'b100) && (ws != 3'b101);
    if (i == 0) return 1'b0;
    if (i <= nd) return d[i-1];
    if (hasPar && i == nd + 1) begin
      ones = 0;
      for (int k = 0; k < nd; k++) ones += int'(d[k]);
      return ws[0] ? (ones % 2 == 0) : (ones % 2 == 1);
    end
    return 1'b1;
  endfunction

  task automatic pushFrame(input logic [7:0] d, input logic [2:0] ws, input logic [1:0] ds);
    for (int i = 0; i < expLen(ws); i++)
      for (int j = 0; j < divOf(ds); j++) begin
        expStream[expN] = expBit(d, ws, i);
        expN++;
      end
  endtask

  // One clock cycle: record the line for a tick slot, then drive inputs.
  task automatic cyc(input bit tk, input bit ld, input logic [7:0] d);
    @(negedge clk);
    if (tk && logN < LOG_MAX) begin
      lineLog[logN] = txLine;
      logN++;
    end
    txTick = tk;
    loadStrobe = ld;
    loadData = d;
  endtask

  task automatic compareLog(input string req, input string what);
    int bad;
    bit expv;
    bad = -1;
    for (int i = 0; i < logN; i++) begin
      expv = (i < expN) ? expStream[i] : 1'b1;
      if (bad < 0 && lineLog[i] != expv) bad = i;
    end
    check(bad < 0, req, $sformatf("%s line at tick slot %0d", what, bad),
          (bad < 0) ? 0 : int'(lineLog[bad]), (bad < 0) ? 0 : int'(expStream[bad]));
  endtask

  task automatic runFrame(input logic [7:0] d, input logic [2:0] ws, input logic [1:0] ds,
                          input int prob, input string req);
    cyc(0, 0, 8'h00);
    wordSel = ws;
    divSel = ds;
    cyc(0, 0, 8'h00);
    logN = 0;
    expN = 0;
    expStream[expN] = 1'b1;
    expN++;
    pushFrame(d, ws, ds);
    cyc(0, 1, d);
    while (logN < expN + 3) cyc($urandom_range(99) < prob, 0, 8'h00);
    compareLog(req, $sformatf("data=%02h ws=%0d ds=%0d", d, ws, ds));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1", "idle line", int'(txLine), 1);
    check(holdEmpty == 1'b1, "R1", "empty flag", int'(holdEmpty), 1);

    // R3 / R2: every format code, fast ticks
    for (int w = 0; w < 8; w++) runFrame(8'hC3 ^ 8'(w * 17), 3'(w), 2'b00, 100, "R3");

    // R4: parity sense
    runFrame(8'h01, 3'b110, 2'b00, 100, "R4 even");
    runFrame(8'h01, 3'b111, 2'b00, 100, "R4 odd");
    // R5: bit 7 ignored in 7-bit formats (expected built from 7 bits)
    runFrame(8'h80, 3'b011, 2'b00, 100, "R5");
    // R6: bit durations
    runFrame(8'h5A, 3'b101, 2'b01, 100, "R6 div16");
    runFrame(8'hA6, 3'b000, 2'b10, 100, "R6 div64");

    // R7 / R11: empty flag timing and tick-only changes
    wordSel = 3'b101;
    divSel = 2'b00;
    cyc(0, 1, 8'h3C);
    cyc(0, 0, 8'h00);
    check(holdEmpty == 1'b0, "R7", "empty after load", int'(holdEmpty), 0);
    cyc(0, 0, 8'h00);
    cyc(0, 0, 8'h00);
    check(txLine == 1'b1 && holdEmpty == 1'b0, "R11", "no start without tick",
          int'(txLine), 1);
    cyc(1, 0, 8'h00);
    cyc(0, 0, 8'h00);
    check(holdEmpty == 1'b1, "R7", "empty at frame start", int'(holdEmpty), 1);
    check(txLine == 1'b0, "R2", "start bit low", int'(txLine), 0);
    cyc(0, 0, 8'h00);
    cyc(0, 0, 8'h00);
    check(txLine == 1'b0, "R11", "line holds without tick", int'(txLine), 0);
    repeat (14) cyc(1, 0, 8'h00);

    // R8: back-to-back characters
    wordSel = 3'b010;
    divSel = 2'b00;
    cyc(0, 0, 8'h00);
    logN = 0;
    expN = 0;
    expStream[expN] = 1'b1;
    expN++;
    pushFrame(8'h4E, 3'b010, 2'b00);
    pushFrame(8'h31, 3'b010, 2'b00);
    cyc(0, 1, 8'h4E);
    cyc(1, 0, 8'h00);
    cyc(1, 0, 8'h00);
    cyc(1, 1, 8'h31);
    while (logN < expN + 3) cyc(1, 0, 8'h00);
    compareLog("R8", "queued frame");

    // R9: break and non-break control codes
    txCtrl = 2'b11;
    repeat (4) cyc(1, 0, 8'h00);
    check(txLine == 1'b0, "R9", "break low", int'(txLine), 0);
    cyc(0, 0, 8'h00);
    check(txLine == 1'b0, "R9", "break held", int'(txLine), 0);
    txCtrl = 2'b00;
    cyc(0, 0, 8'h00);
    check(txLine == 1'b1, "R9", "break released", int'(txLine), 1);
    txCtrl = 2'b10;
    runFrame(8'h96, 3'b111, 2'b00, 100, "R9 code 10");
    txCtrl = 2'b01;
    runFrame(8'h69, 3'b001, 2'b00, 100, "R9 code 01");
    txCtrl = 2'b00;

    // R10: master reset mid-frame
    wordSel = 3'b101;
    divSel = 2'b01;
    cyc(0, 1, 8'h00);
    repeat (20) cyc(1, 0, 8'h00);
    divSel = 2'b11;
    cyc(1, 1, 8'hFF);
    cyc(1, 0, 8'h00);
    check(txLine == 1'b1, "R10", "line idle after reset", int'(txLine), 1);
    check(holdEmpty == 1'b1, "R10", "empty after reset", int'(holdEmpty), 1);
    divSel = 2'b00;
    logN = 0;
    expN = 0;
    repeat (40) cyc(1, 0, 8'h00);
    compareLog("R10", "no frame after reset");

    // R3 / R6 random frames with irregular ticks
    for (int n = 0; n < 30; n++)
      runFrame(8'($urandom), 3'($urandom_range(7)), 2'($urandom_range(2)),
               50 + $urandom_range(50), "R3 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule